// File: doc/BRIEF.md
# Rename Stage Flow Controller

This block is the flow-control unit of a single-thread register rename stage. Each cycle decode may present a group of up to `WIDTH` instructions, each with a valid bit, a serializing flag and a sequence number. The controller decides in that same cycle how many of them pass downstream. The decision depends on the free entries in the reorder buffer, the issue queue and the load/store queue, and on whether a serializing instruction is waiting for the reorder buffer to drain. Register mapping is done elsewhere. This block only chooses which instructions go, in what order, and when decode must stop.

Instructions that reach the stage but cannot go on are kept in a skid buffer with `WIDTH` entries. Held instructions always leave before any new decode input, oldest first. A stall request to decode is raised in the same cycle as the decision that holds instructions. It stays high until the held queue is empty. A squash request empties the skid buffer and drops the decode group of that cycle.

Decode must not present a group in a cycle that follows a cycle with `stallDecode` high.

Top module: `rename_flow_ctrl`

## Requirements
- R1: After reset `stageState` reads Idle, no output lane is valid and `stallDecode` is low.
- R2: `stageState` encodes Running=0, Idle=1, StartSquash=2, Squashing=3, Blocked=4, Unblocking=5, SerializeStall=6. In Running or Idle with enough room, valid decode lanes (lane 0 oldest) are renamed in the same cycle. They are packed into output lanes from lane 0 upward in age order, and unused output lanes are invalid with sequence 0.
- R3: A cycle in Running with no decode input and nothing held leads to Idle. Idle holds no instructions. A valid group presented in Idle is renamed in that cycle and the next state is Running.
- R4: Room is the smallest of the three free counts. If the instructions ready to go this cycle outnumber the room, none is sent, `stallDecode` rises in that cycle, the group is held and the next state is Blocked.
- R5: Blocked sends nothing. It stays Blocked while the room is short. It moves to Unblocking in the cycle after the room covers the held instructions.
- R6: Unblocking sends held instructions oldest first, up to `WIDTH` per cycle. `stallDecode` stays high until the cycle in which the held queue empties. That cycle drives it low, and the next state is Running.
- R7: When a serializing instruction follows older ones, the older ones are sent. The serializing instruction and all younger ones are held, the next state is SerializeStall and `stallDecode` is high.
- R8: A serializing instruction at the head is sent alone on lane 0, and only in a cycle where `robEmpty` is high and `robInFlight` is zero. The held instructions younger than it follow it in order.
- R9: `squashReq` discards every held instruction and the decode group of that cycle, and blocks output. The next state is StartSquash. The state is Squashing while the request stays high, and Running after it drops.
- R10: The held queue never exceeds `WIDTH` entries. A decode group presented in any state other than Running or Idle is ignored and never appears on the outputs.
- R11: The number of valid output lanes in a cycle never exceeds the room. A group exactly as large as the room is sent whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| decValid | input | WIDTH | Valid bit per decode lane |
| decSerial | input | WIDTH | Serializing flag per decode lane |
| decSeq | input | WIDTH*SEQ_W | Sequence number per lane, lane 0 in the low bits |
| robFree | input | FREE_W | Free reorder buffer entries |
| iqFree | input | FREE_W | Free issue queue entries |
| lsqFree | input | FREE_W | Free load/store queue entries |
| robEmpty | input | 1 | Reorder buffer holds no instructions |
| robInFlight | input | FREE_W | Instructions on the way to the reorder buffer |
| squashReq | input | 1 | Squash request |
| outValid | output | WIDTH | Valid bit per renamed output lane |
| outSeq | output | WIDTH*SEQ_W | Sequence number per output lane |
| stallDecode | output | 1 | Decode must not send next cycle |
| stageState | output | 3 | Current controller state |

## Verification
The assertions check every cycle that held instructions never exceed `WIDTH` and that no cycle sends more than the room. They also check that a serializing instruction only leaves alone with an empty, quiet reorder buffer, and that Blocked and the squash states produce no output. Two further cycle checks cover the buffer: a cycle with `stallDecode` low leaves nothing held, and a squash always lands in a squash state. Only the bench scenarios can show the full ordering. That covers the sequence numbers on each lane, held instructions released before young ones, the barrier released when the reorder buffer drains, and groups presented during a stall or squash never reaching the outputs.

// File: rtl/rename_fc_pkg.sv
package rename_fc_pkg;
  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_IDLE     = 3'd1,
    ST_SQ_START = 3'd2,
    ST_SQ_BUSY  = 3'd3,
    ST_BLOCK    = 3'd4,
    ST_UNBLOCK  = 3'd5,
    ST_SER_WAIT = 3'd6
  } stage_state_e;

  localparam int SHIFT_W = 8;

  // strobes from the controller to the skid datapath
  typedef struct packed {
    logic               flush;   // drop all held instructions
    logic [SHIFT_W-1:0] shift;   // number of candidates sent this cycle
  } skid_strobe_t;
endpackage

// File: rtl/rename_fc_skid.sv
module rename_fc_skid import rename_fc_pkg::*; #(
  parameter int WIDTH = 4,
  parameter int SEQ_W = 8,
  parameter int CNT_W = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   takeDec,
  input  logic [WIDTH-1:0]       decValid,
  input  logic [WIDTH-1:0]       decSerial,
  input  logic [WIDTH*SEQ_W-1:0] decSeq,
  input  skid_strobe_t           stb,
  output logic [CNT_W-1:0]       candCnt,
  output logic [CNT_W-1:0]       runLen,
  output logic                   headSer,
  output logic                   leftHeadSer,
  output logic [WIDTH-1:0]       outValid,
  output logic [WIDTH*SEQ_W-1:0] outSeq,
  output logic                   sentBarrier,
  output logic [CNT_W-1:0]       skidLevel
);
  localparam int CAND = 2 * WIDTH;

  logic [SEQ_W-1:0] skidSeqQ [WIDTH];
  logic [WIDTH-1:0] skidSerQ;
  logic [CNT_W-1:0] skidCntQ;

  logic [SEQ_W-1:0] candSeq [CAND];
  logic             candSer [CAND];
  int               candN;

  logic [SEQ_W-1:0] nxtSeq [WIDTH];
  logic [WIDTH-1:0] nxtSer;
  int               nxtCnt;

  // held entries first (oldest), then the compacted decode lanes
  always_comb begin : buildCand
    int n;
    n = int'(skidCntQ);
    for (int i = 0; i < CAND; i++) begin
      candSeq[i] = '0;
      candSer[i] = 1'b0;
    end
    for (int i = 0; i < WIDTH; i++) begin
      if (i < int'(skidCntQ)) begin
        candSeq[i] = skidSeqQ[i];
        candSer[i] = skidSerQ[i];
      end
    end
    if (takeDec) begin
      for (int i = 0; i < WIDTH; i++) begin
        if (decValid[i] && n < CAND) begin
          candSeq[n] = decSeq[i*SEQ_W +: SEQ_W];
          candSer[n] = decSerial[i];
          n++;
        end
      end
    end
    candN = n;
  end

  // leading run of non-serializing candidates, capped at WIDTH
  always_comb begin : scanRun
    logic stop;
    int   len;
    stop = 1'b0;
    len  = 0;
    for (int i = 0; i < WIDTH; i++) begin
      if (!stop && i < candN && !candSer[i]) len++;
      else stop = 1'b1;
    end
    runLen  = CNT_W'(len);
    candCnt = CNT_W'(candN);
    headSer = (candN > 0) && candSer[0];
  end

  // send the first shift candidates, keep the rest
  always_comb begin : sendKeep
    int s;
    s = int'(stb.shift);
    outValid    = '0;
    outSeq      = '0;
    sentBarrier = 1'b0;
    leftHeadSer = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      if (i < s) begin
        outValid[i]                = 1'b1;
        outSeq[i*SEQ_W +: SEQ_W]   = candSeq[i];
        if (candSer[i]) sentBarrier = 1'b1;
      end
    end
    if (s < candN && s < CAND) leftHeadSer = candSer[s];
    for (int i = 0; i < WIDTH; i++) begin
      nxtSeq[i] = '0;
      nxtSer[i] = 1'b0;
      if (i + s < CAND) begin
        nxtSeq[i] = candSeq[i + s];
        nxtSer[i] = candSer[i + s];
      end
    end
    nxtCnt = stb.flush ? 0 : candN - s;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      skidCntQ <= '0;
      skidSerQ <= '0;
      for (int i = 0; i < WIDTH; i++) skidSeqQ[i] <= '0;
    end else begin
      skidCntQ <= CNT_W'(nxtCnt);
      skidSerQ <= nxtSer;
      for (int i = 0; i < WIDTH; i++) skidSeqQ[i] <= nxtSeq[i];
    end
  end

  assign skidLevel = skidCntQ;

  // R10: what remains after a send must fit the skid buffer
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (nxtCnt >= 0) && (nxtCnt <= WIDTH));
endmodule

// File: rtl/rename_fc_ctrl.sv
module rename_fc_ctrl import rename_fc_pkg::*; #(
  parameter int WIDTH  = 4,
  parameter int FREE_W = 6,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              squashReq,
  input  logic [FREE_W-1:0] robFree,
  input  logic [FREE_W-1:0] iqFree,
  input  logic [FREE_W-1:0] lsqFree,
  input  logic              robEmpty,
  input  logic [FREE_W-1:0] robInFlight,
  input  logic [CNT_W-1:0]  candCnt,
  input  logic [CNT_W-1:0]  runLen,
  input  logic              headSer,
  input  logic              leftHeadSer,
  output logic              takeDec,
  output skid_strobe_t      stb,
  output logic              stallDecode,
  output logic [2:0]        stageState
);
  stage_state_e      stateQ, stateD;
  logic [FREE_W-1:0] minFree;
  logic              barrierOk, roomShort;
  int                wantK;

  assign takeDec = !squashReq && (stateQ == ST_RUN || stateQ == ST_IDLE);

  always_comb begin : pickSend
    barrierOk = robEmpty && (robInFlight == '0);
    minFree   = robFree;
    if (iqFree  < minFree) minFree = iqFree;
    if (lsqFree < minFree) minFree = lsqFree;
    wantK     = headSer ? (barrierOk ? 1 : 0) : int'(runLen);
    roomShort = (wantK > 0) && (int'(minFree) < wantK);
    stb       = '0;
    if (squashReq) stb.flush = 1'b1;
    else if ((stateQ inside {ST_RUN, ST_IDLE, ST_UNBLOCK, ST_SER_WAIT}) && !roomShort)
      stb.shift = SHIFT_W'(wantK);
  end

  always_comb begin : pickNext
    int leftCnt;
    leftCnt = int'(candCnt) - int'(stb.shift);
    stateD  = stateQ;
    if (squashReq) begin
      stateD = (stateQ inside {ST_SQ_START, ST_SQ_BUSY}) ? ST_SQ_BUSY : ST_SQ_START;
    end else begin
      case (stateQ)
        ST_SQ_START, ST_SQ_BUSY: stateD = ST_RUN;
        ST_BLOCK:                stateD = roomShort ? ST_BLOCK : ST_UNBLOCK;
        default: begin
          if (roomShort)                        stateD = ST_BLOCK;
          else if (leftCnt > 0)                 stateD = leftHeadSer ? ST_SER_WAIT : ST_UNBLOCK;
          else if (candCnt == '0 && (stateQ inside {ST_RUN, ST_IDLE}))
                                                stateD = ST_IDLE;
          else                                  stateD = ST_RUN;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign stallDecode = !(stateD inside {ST_RUN, ST_IDLE});
  assign stageState  = stateQ;

  // R9: a squash request always lands in a squash state
  a_r9_squash_enter: assert property (@(posedge clk) disable iff (!rstN)
    squashReq |=> (stateQ inside {ST_SQ_START, ST_SQ_BUSY}));

  // R5: Blocked only leaves toward Unblocking or a squash
  a_r5_block_exit: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_BLOCK) |=> (stateQ inside {ST_BLOCK, ST_UNBLOCK, ST_SQ_START}));
endmodule

// File: rtl/rename_flow_ctrl.sv
module rename_flow_ctrl import rename_fc_pkg::*; #(
  parameter int WIDTH  = 4,
  parameter int SEQ_W  = 8,
  parameter int FREE_W = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [WIDTH-1:0]       decValid,
  input  logic [WIDTH-1:0]       decSerial,
  input  logic [WIDTH*SEQ_W-1:0] decSeq,
  input  logic [FREE_W-1:0]      robFree,
  input  logic [FREE_W-1:0]      iqFree,
  input  logic [FREE_W-1:0]      lsqFree,
  input  logic                   robEmpty,
  input  logic [FREE_W-1:0]      robInFlight,
  input  logic                   squashReq,
  output logic [WIDTH-1:0]       outValid,
  output logic [WIDTH*SEQ_W-1:0] outSeq,
  output logic                   stallDecode,
  output logic [2:0]             stageState
);
  localparam int CNT_W = $clog2(2 * WIDTH + 1);

  skid_strobe_t     stb;
  logic             takeDec, headSer, leftHeadSer, sentBarrier;
  logic [CNT_W-1:0] candCnt, runLen, skidLevel;
  logic [FREE_W-1:0] roomNow;

  rename_fc_ctrl #(.WIDTH(WIDTH), .FREE_W(FREE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .squashReq(squashReq),
    .robFree(robFree), .iqFree(iqFree), .lsqFree(lsqFree),
    .robEmpty(robEmpty), .robInFlight(robInFlight),
    .candCnt(candCnt), .runLen(runLen), .headSer(headSer), .leftHeadSer(leftHeadSer),
    .takeDec(takeDec), .stb(stb), .stallDecode(stallDecode), .stageState(stageState)
  );

  rename_fc_skid #(.WIDTH(WIDTH), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_skid (
    .clk(clk), .rstN(rstN), .takeDec(takeDec),
    .decValid(decValid), .decSerial(decSerial), .decSeq(decSeq), .stb(stb),
    .candCnt(candCnt), .runLen(runLen), .headSer(headSer), .leftHeadSer(leftHeadSer),
    .outValid(outValid), .outSeq(outSeq), .sentBarrier(sentBarrier), .skidLevel(skidLevel)
  );

  // independent room figure, used only by the checks below
  always_comb begin
    roomNow = robFree;
    if (iqFree  < roomNow) roomNow = iqFree;
    if (lsqFree < roomNow) roomNow = lsqFree;
  end

  // R11: never more lanes than the tightest queue can take
  a_r11_room: assert property (@(posedge clk) disable iff (!rstN)
    $countones(outValid) <= int'(roomNow));

  // R8: a barrier leaves alone and only with a quiet, empty reorder buffer
  a_r8_barrier_alone: assert property (@(posedge clk) disable iff (!rstN)
    sentBarrier |-> (outValid == WIDTH'(1)) && robEmpty && (robInFlight == '0));

  // R6: releasing decode means nothing is left held
  a_r6_skid_empty_unstalled: assert property (@(posedge clk) disable iff (!rstN)
    !stallDecode |=> (skidLevel == '0));

  // R5: Blocked and the squash states send nothing
  a_r5_quiet_states: assert property (@(posedge clk) disable iff (!rstN)
    (stageState inside {3'd2, 3'd3, 3'd4}) |-> (outValid == '0));
endmodule

// File: tb/rename_flow_ctrl_test.sv
`timescale 1ns/1ps
module rename_flow_ctrl_test;
  localparam int W = 4, SQ = 8, FW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [W-1:0]  decValid = '0, decSerial = '0;
  logic [W*SQ-1:0] decSeq = '0;
  logic [FW-1:0] robFree = 6'd20, iqFree = 6'd20, lsqFree = 6'd20, robInFlight = '0;
  logic          robEmpty = 1'b1, squashReq = 1'b0;
  logic [W-1:0]  outValid;
  logic [W*SQ-1:0] outSeq;
  logic          stallDecode;
  logic [2:0]    stageState;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  rename_flow_ctrl #(.WIDTH(W), .SEQ_W(SQ), .FREE_W(FW)) uut (
    .clk(clk), .rstN(rstN), .decValid(decValid), .decSerial(decSerial), .decSeq(decSeq),
    .robFree(robFree), .iqFree(iqFree), .lsqFree(lsqFree), .robEmpty(robEmpty),
    .robInFlight(robInFlight), .squashReq(squashReq), .outValid(outValid),
    .outSeq(outSeq), .stallDecode(stallDecode), .stageState(stageState)
  );

  function automatic logic [31:0] lanes(input logic [7:0] a, b, c, d);
    return {d, c, b, a};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #2; endtask
  task automatic settle(); #1; endtask
  task automatic setDec(input logic [3:0] v, input logic [3:0] s, input logic [31:0] q);
    decValid = v; decSerial = s; decSeq = q;
  endtask
  task automatic clearDec(); setDec(4'b0, 4'b0, 32'h0); endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic testReset();
    tick(); settle();
    check("R1 state", stageState, 3'd1);
    check("R1 outValid", outValid, 4'b0);
    check("R1 stall", stallDecode, 1'b0);
    rstN = 1'b1;
    tick();
  endtask

  task automatic testRun();
    robFree = 6'd4;
    setDec(4'b1111, 4'b0, lanes(10, 11, 12, 13)); settle();
    check("R3 idle group renamed", outValid, 4'b1111);
    check("R11 exact room", outSeq, lanes(10, 11, 12, 13));
    check("R2 stall low", stallDecode, 1'b0);
    tick(); clearDec(); robFree = 6'd20; settle();
    check("R3 running", stageState, 3'd0);
    check("R2 no input no output", outValid, 4'b0);
    tick(); settle();
    check("R3 idle", stageState, 3'd1);
    setDec(4'b0101, 4'b0, lanes(20, 21, 22, 23)); settle();
    check("R2 sparse valid", outValid, 4'b0011);
    check("R2 sparse seq", outSeq, lanes(20, 22, 0, 0));
    tick(); clearDec(); tick();
  endtask

  task automatic testBlock();
    robFree = 6'd3;
    setDec(4'b1111, 4'b0, lanes(30, 31, 32, 33)); settle();
    check("R4 nothing sent", outValid, 4'b0);
    check("R4 stall same cycle", stallDecode, 1'b1);
    tick(); setDec(4'b1111, 4'b0, lanes(40, 41, 42, 43)); settle();
    check("R4 blocked", stageState, 3'd4);
    check("R5 blocked quiet", outValid, 4'b0);
    tick(); clearDec(); robFree = 6'd20; settle();
    check("R5 still blocked", stageState, 3'd4);
    check("R5 no send on exit", outValid, 4'b0);
    check("R6 stall kept", stallDecode, 1'b1);
    tick(); settle();
    check("R5 unblocking", stageState, 3'd5);
    check("R6 drain valid", outValid, 4'b1111);
    check("R6 drain order", outSeq, lanes(30, 31, 32, 33));
    check("R6 stall drops", stallDecode, 1'b0);
    tick(); settle();
    check("R6 running", stageState, 3'd0);
    check("R10 ignored group", outValid, 4'b0);
    tick();
    lsqFree = 6'd3;
    setDec(4'b1111, 4'b0, lanes(1, 2, 3, 4)); settle();
    check("R4 lsq short", stallDecode, 1'b1);
    tick(); clearDec(); lsqFree = 6'd20; settle();
    check("R4 lsq blocked", stageState, 3'd4);
    tick(); settle();
    check("R6 lsq drain", outSeq, lanes(1, 2, 3, 4));
    tick(); tick();
  endtask

  task automatic testSerial();
    robEmpty = 1'b0;
    setDec(4'b1111, 4'b0010, lanes(50, 51, 52, 53)); settle();
    check("R7 older sent", outValid, 4'b0001);
    check("R7 older seq", outSeq, lanes(50, 0, 0, 0));
    check("R7 stall", stallDecode, 1'b1);
    tick(); clearDec(); settle();
    check("R7 ser stall", stageState, 3'd6);
    check("R7 held", outValid, 4'b0);
    robEmpty = 1'b1; robInFlight = 6'd3; settle();
    check("R8 in flight holds", outValid, 4'b0);
    tick(); robInFlight = '0; settle();
    check("R8 still stalled", stageState, 3'd6);
    check("R8 alone", outValid, 4'b0001);
    check("R8 barrier seq", outSeq, lanes(51, 0, 0, 0));
    check("R8 stall", stallDecode, 1'b1);
    tick(); settle();
    check("R8 unblocking", stageState, 3'd5);
    check("R8 younger follow", outSeq, lanes(52, 53, 0, 0));
    check("R8 younger valid", outValid, 4'b0011);
    tick(); settle();
    check("R8 running", stageState, 3'd0);
    tick();
    setDec(4'b1111, 4'b0001, lanes(60, 61, 62, 63)); settle();
    check("R8 head barrier alone", outValid, 4'b0001);
    check("R8 head barrier seq", outSeq, lanes(60, 0, 0, 0));
    tick(); clearDec(); settle();
    check("R8 rest after barrier", outSeq, lanes(61, 62, 63, 0));
    tick(); tick();
  endtask

  task automatic testSquash();
    robFree = 6'd1;
    setDec(4'b1111, 4'b0, lanes(70, 71, 72, 73)); settle();
    check("R4 block before squash", stallDecode, 1'b1);
    tick(); clearDec(); squashReq = 1'b1; settle();
    check("R9 no output", outValid, 4'b0);
    check("R9 stall", stallDecode, 1'b1);
    tick(); settle();
    check("R9 start squash", stageState, 3'd2);
    tick(); squashReq = 1'b0; settle();
    check("R9 squashing", stageState, 3'd3);
    check("R9 release", stallDecode, 1'b0);
    tick(); robFree = 6'd20; settle();
    check("R9 running", stageState, 3'd0);
    check("R9 skid discarded", outValid, 4'b0);
    tick();
    setDec(4'b1111, 4'b0, lanes(80, 81, 82, 83)); squashReq = 1'b1; settle();
    check("R9 decode dropped", outValid, 4'b0);
    tick(); clearDec(); squashReq = 1'b0; settle();
    check("R9 start squash 2", stageState, 3'd2);
    tick(); settle();
    check("R9 nothing left", outValid, 4'b0);
    tick();
  endtask

  initial begin
    testReset();
    testRun();
    testBlock();
    testSerial();
    testSquash();
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finishRun();
  end
endmodule